// File: doc/BRIEF.md
# Six-Channel DAC Input Load Controller

This block is the digital front end of a six-channel video DAC. Every clock period it can take one 10-bit sample (bit 9 is the most significant bit) and place it in one of six input latches. The sample is captured on the rising or the falling clock edge, depending on a static edge-select strap. The target latch comes from one of two sources. In direct mode a channel address names the latch. In sequenced mode an internal counter walks the channels upward or downward after a start pulse.

A transfer request copies all six input latches at once into six holding registers that drive the converters. The request is sampled on a rising clock edge, and the copy happens on the following falling edge. A standby input freezes all loading and transfer activity.

The edge-select strap is treated as configuration: it changes only while reset is held.

Top module: `dac_load_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high) clears all input latches, all holding registers and the sequencer, so `dac_word` reads zero and `seq_busy` is low.
- R2: With `edge_sel` low, samples are captured on the falling clock edge. With `edge_sel` high, they are captured on the rising edge.
- R3: At a capture edge with `ch_addr` between 0 and 5 and `start_cs` high, `din` is written into input latch number `ch_addr`.
- R4: At a capture edge with `ch_addr` between 0 and 5 and `start_cs` low, no input latch changes.
- R5: Address value 6 is reserved. At such an edge no latch changes and the sequencer neither advances nor restarts.
- R6: At a capture edge with `ch_addr` = 7 and `start_cs` high, the sequencer becomes busy and loads no data. The next channel is set to 0 when `seq_down` is low, or to 5 when it is high. `seq_down` is sampled only at this edge.
- R7: While busy, each capture edge with `ch_addr` = 7 and `start_cs` low writes `din` into the current channel. The channel then steps up by one (direction low) or down by one (direction high). Edges carrying any other address leave the channel pointer unchanged.
- R8: After the sixth sequenced write (channel 5 going up, channel 0 going down), `seq_busy` falls. Further address-7 words are ignored until a new start pulse arrives. A start pulse while busy restarts the sequence.
- R9: If `xfer_req` is high at a rising clock edge, all six input latches are copied into the holding registers on the next falling edge. The copy takes the latch values present just before that falling edge. Without a request, the holding registers keep their values.
- R10: While `standby` is high at an edge, no latch is written, no transfer is armed or performed, and the sequencer returns to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| edge_sel | input | 1 | Capture-edge strap: 0 selects the falling edge, 1 the rising edge |
| seq_down | input | 1 | Sequence direction: 0 counts up, 1 counts down |
| ch_addr | input | 3 | Channel address: 0-5 direct, 6 reserved, 7 sequenced |
| start_cs | input | 1 | Chip select in direct mode, start pulse in sequenced mode |
| din | input | 10 | Sample word, bit 9 most significant |
| xfer_req | input | 1 | Transfer request, sampled on the rising edge |
| standby | input | 1 | Freezes loading and transfer, idles the sequencer |
| dac_word | output | 60 | Holding registers; channel n occupies bits n*10+9 down to n*10 |
| seq_busy | output | 1 | High while a sequence is in progress |

## Verification
The bench builds the block with its default parameters: a 10-bit data width and six channels, which gives a 3-bit address with code 6 reserved and code 7 for sequencing. These defaults allow both sequence directions to be walked end to end, the reserved code to be exercised, and a restart to be issued partway through a sequence. The same vector table is replayed under both capture-edge settings. A probe that changes the data between the falling and rising edges shows which edge was used. Because the reserved code exists at these parameter values, the bench has a neutral idle address between vectors.

// File: rtl/dacld_pkg.sv
package dacld_pkg;

    localparam int unsigned DATA_W_DEF = 10;
    localparam int unsigned NUM_CH_DEF = 6;

    // Kind of work requested at a capture edge
    typedef enum logic [1:0] {
        CAP_IDLE   = 2'd0,
        CAP_DIRECT = 2'd1,
        CAP_START  = 2'd2,
        CAP_STEP   = 2'd3
    } cap_op_e;

    // Channel a sequence begins on
    function automatic int unsigned seq_first(input logic down, input int unsigned nch);
        return down ? nch - 1 : 0;
    endfunction

    // Channel a sequence ends on
    function automatic int unsigned seq_last(input logic down, input int unsigned nch);
        return down ? 0 : nch - 1;
    endfunction

endpackage

// File: rtl/dacld_decode.sv
module dacld_decode
    import dacld_pkg::*;
#(
    parameter int unsigned NUM_CH = NUM_CH_DEF,
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned CH_W   = 3
) (
    input  logic [ADDR_W-1:0] ch_addr,
    input  logic              start_cs,
    input  logic              standby,
    output cap_op_e           op,
    output logic [CH_W-1:0]   direct_ch
);
    localparam logic [ADDR_W-1:0] SEQ_CODE = {ADDR_W{1'b1}};

    always_comb begin
        op = CAP_IDLE;
        if (!standby) begin
            if (ch_addr == SEQ_CODE)
                op = start_cs ? CAP_START : CAP_STEP;
            else if ({1'b0, ch_addr} < (ADDR_W+1)'(NUM_CH))
                op = start_cs ? CAP_DIRECT : CAP_IDLE;
        end
    end

    assign direct_ch = CH_W'(ch_addr);

endmodule

// File: rtl/dacld_seq.sv
module dacld_seq
    import dacld_pkg::*;
#(
    parameter int unsigned NUM_CH = NUM_CH_DEF,
    parameter int unsigned CH_W   = 3
) (
    input  logic            cap_clk,
    input  logic            rst,
    input  logic            standby,
    input  logic            seq_down,
    input  cap_op_e         op,
    output logic            busy,
    output logic [CH_W-1:0] ptr,
    output logic            step_wr
);
    localparam logic [CH_W-1:0] TOP_CH = CH_W'(NUM_CH - 1);

    logic            down_q;
    logic [CH_W-1:0] last_ch;

    assign last_ch = CH_W'(seq_last(down_q, NUM_CH));
    assign step_wr = busy && (op == CAP_STEP);

    always_ff @(posedge cap_clk) begin
        if (rst) begin
            busy   <= 1'b0;
            ptr    <= '0;
            down_q <= 1'b0;
        end else if (standby) begin
            busy <= 1'b0;
        end else begin
            case (op)
                CAP_START: begin
                    busy   <= 1'b1;
                    down_q <= seq_down;
                    ptr    <= CH_W'(seq_first(seq_down, NUM_CH));
                end
                CAP_STEP: begin
                    if (busy) begin
                        if (ptr == last_ch)
                            busy <= 1'b0;
                        else if (down_q)
                            ptr <= ptr - 1'b1;
                        else
                            ptr <= ptr + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // R10: standby leaves the sequencer idle
    assert_stby_idle_R10: assert property (@(posedge cap_clk) disable iff (rst)
        standby |=> !busy);

    // R6: a start pulse makes the sequencer busy on the first channel
    assert_start_first_R6: assert property (@(posedge cap_clk) disable iff (rst)
        (op == CAP_START) |=> busy && (ptr == ($past(seq_down) ? TOP_CH : '0)));

    // R8: the write on the last channel ends the sequence
    assert_done_idle_R8: assert property (@(posedge cap_clk) disable iff (rst)
        (step_wr && ptr == last_ch && !standby) |=> !busy);

    // R7: the pointer holds while no step or start occurs
    assert_ptr_hold_R7: assert property (@(posedge cap_clk) disable iff (rst)
        (op == CAP_IDLE || op == CAP_DIRECT) |=> $stable(ptr));

endmodule

// File: rtl/dacld_bank.sv
module dacld_bank
    import dacld_pkg::*;
#(
    parameter int unsigned DATA_W = DATA_W_DEF,
    parameter int unsigned NUM_CH = NUM_CH_DEF,
    parameter int unsigned CH_W   = 3
) (
    input  logic                     cap_clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [CH_W-1:0]          wr_ch,
    input  logic [DATA_W-1:0]        din,
    output logic [NUM_CH*DATA_W-1:0] lat_flat
);
    logic [DATA_W-1:0] lat_q [NUM_CH];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_ff @(posedge cap_clk) begin
            if (rst)
                lat_q[c] <= '0;
            else if (wr_en && wr_ch == CH_W'(c))
                lat_q[c] <= din;
        end
        assign lat_flat[c*DATA_W +: DATA_W] = lat_q[c];
    end

    // R4: without a write request every latch holds
    assert_no_write_stable_R4: assert property (@(posedge cap_clk) disable iff (rst)
        !wr_en |=> $stable(lat_flat));

    // R3: a write lands the sample in the addressed latch
    assert_write_lands_R3: assert property (@(posedge cap_clk) disable iff (rst)
        wr_en |=> lat_q[$past(wr_ch)] == $past(din));

endmodule

// File: rtl/dacld_xfer.sv
module dacld_xfer
    import dacld_pkg::*;
#(
    parameter int unsigned DATA_W = DATA_W_DEF,
    parameter int unsigned NUM_CH = NUM_CH_DEF
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     xfer_req,
    input  logic                     standby,
    input  logic [NUM_CH*DATA_W-1:0] src,
    output logic [NUM_CH*DATA_W-1:0] hold
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst)
            armed <= 1'b0;
        else
            armed <= xfer_req && !standby;
    end

    always_ff @(negedge clk) begin
        if (rst)
            hold <= '0;
        else if (armed && !standby)
            hold <= src;
    end

    // R10: standby at a rising edge leaves nothing armed
    assert_stby_noarm_R10: assert property (@(posedge clk) disable iff (rst)
        standby |=> !armed);

    // R9: holding registers move only when armed
    assert_hold_stable_R9: assert property (@(negedge clk) disable iff (rst)
        !armed |=> $stable(hold));

    // R9: an armed falling edge with standby low copies the pre-edge latches
    assert_copy_R9: assert property (@(negedge clk) disable iff (rst)
        (armed && !standby) |=> hold == $past(src));

endmodule

// File: rtl/dac_load_ctrl.sv
module dac_load_ctrl
    import dacld_pkg::*;
#(
    parameter int unsigned DATA_W = DATA_W_DEF,
    parameter int unsigned NUM_CH = NUM_CH_DEF
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     edge_sel,
    input  logic                     seq_down,
    input  logic [2:0]               ch_addr,
    input  logic                     start_cs,
    input  logic [DATA_W-1:0]        din,
    input  logic                     xfer_req,
    input  logic                     standby,
    output logic [NUM_CH*DATA_W-1:0] dac_word,
    output logic                     seq_busy
);
    localparam int unsigned ADDR_W = 3;
    localparam int unsigned CH_W   = $clog2(NUM_CH);

    // Capture clock: edge_sel is a strap changed only under reset
    logic cap_clk;
    assign cap_clk = edge_sel ? clk : ~clk;

    cap_op_e               op;
    logic [CH_W-1:0]       direct_ch;
    logic [CH_W-1:0]       seq_ptr;
    logic                  step_wr;
    logic                  wr_en;
    logic [CH_W-1:0]       wr_ch;
    logic [NUM_CH*DATA_W-1:0] lat_flat;

    dacld_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CH_W(CH_W)) u_decode (
        .ch_addr  (ch_addr),
        .start_cs (start_cs),
        .standby  (standby),
        .op       (op),
        .direct_ch(direct_ch)
    );

    dacld_seq #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_seq (
        .cap_clk (cap_clk),
        .rst     (rst),
        .standby (standby),
        .seq_down(seq_down),
        .op      (op),
        .busy    (seq_busy),
        .ptr     (seq_ptr),
        .step_wr (step_wr)
    );

    assign wr_en = (op == CAP_DIRECT) || step_wr;
    assign wr_ch = (op == CAP_DIRECT) ? direct_ch : seq_ptr;

    dacld_bank #(.DATA_W(DATA_W), .NUM_CH(NUM_CH), .CH_W(CH_W)) u_bank (
        .cap_clk (cap_clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_ch   (wr_ch),
        .din     (din),
        .lat_flat(lat_flat)
    );

    dacld_xfer #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_xfer (
        .clk     (clk),
        .rst     (rst),
        .xfer_req(xfer_req),
        .standby (standby),
        .src     (lat_flat),
        .hold    (dac_word)
    );

    // R5: the reserved code never produces a write
    assert_reserved_nowrite_R5: assert property (@(posedge cap_clk) disable iff (rst)
        (ch_addr == 3'd6) |-> !wr_en);

endmodule

// File: tb/tb_dac_load_ctrl.sv
module tb_dac_load_ctrl;
    localparam int DW  = 10;
    localparam int NCH = 6;
    localparam int NROWS = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic edge_sel = 1'b0;
    logic seq_down = 1'b0;
    logic [2:0] ch_addr = 3'd6;
    logic start_cs = 1'b0;
    logic [DW-1:0] din = '0;
    logic xfer_req = 1'b0;
    logic standby = 1'b0;
    logic [NCH*DW-1:0] dac_word;
    logic seq_busy;

    int vectors = 0;
    int misses = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dac_load_ctrl dut (
        .clk(clk), .rst(rst), .edge_sel(edge_sel), .seq_down(seq_down),
        .ch_addr(ch_addr), .start_cs(start_cs), .din(din),
        .xfer_req(xfer_req), .standby(standby),
        .dac_word(dac_word), .seq_busy(seq_busy)
    );

    // Row: {xfer, stby, dir, cs, addr[2:0], data[9:0]}
    localparam logic [16:0] ROWS [NROWS] = '{
        {1'b0,1'b0,1'b0,1'b1,3'd0,10'h155}, // R3 direct ch0
        {1'b0,1'b0,1'b0,1'b1,3'd5,10'h2AA}, // R3 direct ch5
        {1'b0,1'b0,1'b0,1'b0,3'd2,10'h3FF}, // R4 chip select low
        {1'b0,1'b0,1'b0,1'b1,3'd6,10'h111}, // R5 reserved code
        {1'b1,1'b0,1'b0,1'b0,3'd6,10'h000}, // R9 transfer
        {1'b1,1'b0,1'b0,1'b1,3'd3,10'h200}, // R9 write and transfer together
        {1'b0,1'b0,1'b0,1'b1,3'd7,10'h3FF}, // R6 start upward, no load
        {1'b0,1'b0,1'b0,1'b0,3'd7,10'h001}, // R7 ch0
        {1'b0,1'b0,1'b1,1'b0,3'd7,10'h002}, // R6 direction ignored mid-run, ch1
        {1'b0,1'b0,1'b0,1'b1,3'd1,10'h0AB}, // R7 direct write pauses sequence
        {1'b0,1'b0,1'b0,1'b0,3'd7,10'h003}, // R7 ch2
        {1'b0,1'b0,1'b0,1'b0,3'd7,10'h004}, // R7 ch3
        {1'b0,1'b0,1'b0,1'b0,3'd7,10'h005}, // R7 ch4
        {1'b0,1'b0,1'b0,1'b0,3'd7,10'h006}, // R8 ch5, busy falls
        {1'b1,1'b0,1'b0,1'b0,3'd7,10'h3EE}, // R8 ignored after end, R9 transfer
        {1'b0,1'b0,1'b1,1'b1,3'd7,10'h000}, // R6 start downward
        {1'b0,1'b0,1'b0,1'b0,3'd7,10'h010}, // R7 ch5
        {1'b0,1'b0,1'b0,1'b0,3'd7,10'h020}, // R7 ch4
        {1'b0,1'b0,1'b0,1'b1,3'd7,10'h000}, // R8 restart upward while busy
        {1'b0,1'b0,1'b0,1'b0,3'd7,10'h030}, // R8 restart lands on ch0
        {1'b1,1'b1,1'b0,1'b0,3'd7,10'h040}, // R10 standby blocks all
        {1'b0,1'b0,1'b0,1'b0,3'd7,10'h050}, // R10 sequencer left idle
        {1'b0,1'b1,1'b0,1'b1,3'd0,10'h060}, // R10 standby blocks direct
        {1'b1,1'b0,1'b0,1'b0,3'd6,10'h000}  // R9 final transfer
    };

    logic [DW-1:0] m_lat  [NCH];
    logic [DW-1:0] m_hold [NCH];
    logic m_busy;
    logic m_down;
    int   m_ptr;

    task automatic model_clear();
        for (int c = 0; c < NCH; c++) begin
            m_lat[c] = '0;
            m_hold[c] = '0;
        end
        m_busy = 1'b0;
        m_down = 1'b0;
        m_ptr = 0;
    endtask

    task automatic model_row(input logic [16:0] r);
        logic x, s, d, cs;
        logic [2:0] a;
        logic [DW-1:0] v;
        {x, s, d, cs, a, v} = r;
        if (s) begin
            m_busy = 1'b0;
        end else begin
            if (a == 3'd7) begin
                if (cs) begin
                    m_busy = 1'b1;
                    m_down = d;
                    m_ptr = d ? NCH - 1 : 0;
                end else if (m_busy) begin
                    m_lat[m_ptr] = v;
                    if (m_ptr == (m_down ? 0 : NCH - 1)) m_busy = 1'b0;
                    else m_ptr = m_down ? m_ptr - 1 : m_ptr + 1;
                end
            end else if (a < 3'd6 && cs) begin
                m_lat[a] = v;
            end
            if (x) m_hold = m_lat;
        end
    endtask

    task automatic compare(input string tag);
        logic [NCH*DW-1:0] exp_w;
        for (int c = 0; c < NCH; c++) exp_w[c*DW +: DW] = m_hold[c];
        vectors++;
        if (dac_word !== exp_w || seq_busy !== m_busy) begin
            misses++;
            $display("FAIL %s: dac_word=%h busy=%b expected dac_word=%h busy=%b",
                     tag, dac_word, seq_busy, exp_w, m_busy);
        end
    endtask

    task automatic go_idle();
        ch_addr = 3'd6; start_cs = 1'b0; xfer_req = 1'b0;
        standby = 1'b0; seq_down = 1'b0; din = '0;
    endtask

    // Called at rising edge + 1; returns at rising edge + 1, two periods later
    task automatic run_row(input logic [16:0] r, input string tag);
        {xfer_req, standby, seq_down, start_cs, ch_addr, din} = r;
        @(posedge clk); #1;
        go_idle();
        @(negedge clk); #1;
        model_row(r);
        compare(tag);
        @(posedge clk); #1;
    endtask

    task automatic do_reset(input logic e);
        rst = 1'b1;
        go_idle();
        edge_sel = e;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        model_clear();
    endtask

    // R2: data changes between edges; the captured value reveals the edge
    task automatic edge_probe(input logic e);
        do_reset(e);
        ch_addr = 3'd0; start_cs = 1'b1; din = 10'h1C3;
        @(negedge clk); #1 din = 10'h23C;
        @(posedge clk); #1 go_idle();
        @(posedge clk); #1;
        m_lat[0] = e ? 10'h23C : 10'h1C3;
        run_row({1'b1,1'b0,1'b0,1'b0,3'd6,10'h000}, "R2 capture edge");
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            misses++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        for (int ph = 0; ph < 2; ph++) begin
            do_reset(ph[0]);
            compare("R1 reset state");
            for (int i = 0; i < NROWS; i++)
                run_row(ROWS[i], $sformatf("row %0d edge %0d (R3/R4/R5/R6/R7/R8/R9/R10)", i, ph));
        end

        edge_probe(1'b0);
        edge_probe(1'b1);

        // R1: reset mid-run clears latches, holding registers and sequencer
        run_row({1'b0,1'b0,1'b0,1'b1,3'd4,10'h3C3}, "R3 load before reset");
        run_row({1'b0,1'b0,1'b0,1'b1,3'd7,10'h000}, "R6 start before reset");
        run_row({1'b1,1'b0,1'b0,1'b0,3'd6,10'h000}, "R9 transfer before reset");
        do_reset(1'b1);
        compare("R1 reset clears outputs");
        run_row({1'b1,1'b0,1'b0,1'b0,3'd6,10'h000}, "R1 latches cleared by reset");
        run_row({1'b0,1'b0,1'b0,1'b0,3'd7,10'h155}, "R1 sequencer idle after reset");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule